// File: doc/BRIEF.md
# Dual-Bank Configuration Register File with Burst Access

This block holds the byte-wide configuration map of a serially controlled peripheral. The map has two banks, A and B, over a 32-byte address space. Every bit follows one of a few access rules. Most bits are ordinary read/write storage kept separately per bank. A few control bits exist only in bank A and are mirrored or hidden in bank B. Live status inputs are reflected into the map and cannot be written. A low-voltage flag is latched and then cleared by any access to its byte. The last implemented address shows the signal-strength converter code. Addresses above it read as zero.

A transaction begins with a command. The command carries a base address, a 2-bit length field (the burst moves length+1 bytes), a direction and a bank select. A command is accepted when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while no burst is in progress.

Data bytes then move over a valid/ready stream:
- **Write bursts:** a byte is taken in each cycle in which `wr_valid` and `wr_ready` are both high.
- **Read bursts:** `rd_valid` stays high and `rd_data` presents the current address until `rd_ready` is seen.
- **Back-pressure:** holding `wr_valid` or `rd_ready` low stalls the burst without changing its address. While a read stalls, the live fields of the byte (lock, converter code and low-voltage flag) keep tracking their inputs.

After each moved byte, an internal counter steps to the next address. It returns to 0x00 once it has passed the last implemented address.

Top module: `cfgbank_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block reaches this state:
  - every stored bit loads its bit of `DEF_A` or `DEF_B`, where byte k of the vector sits at bits [8k+7:8k], and bits that are not writable are loaded with 0;
  - the low-voltage latch is cleared;
  - the block is idle, with `cmd_ready`=1, `wr_ready`=0 and `rd_valid`=0.
- R2: An accepted command moves exactly `cmd_len`+1 data bytes. `cmd_ready` stays 0 from acceptance until the last byte has moved, and is 1 in the cycle after that.
- R3: The first byte uses `cmd_addr`, and each later byte uses the address after the previous one. The address after LAST_ADDR, or after any address above it, is 0x00.
- R4: A write byte moves only in a cycle with `wr_valid`&&`wr_ready`, and a read byte only in a cycle with `rd_valid`&&`rd_ready`. During a stall the address and the burst state hold. `wr_ready` is 1 only in write bursts and `rd_valid` only in read bursts.
- R5: Addresses 3 to LAST_ADDR-1, and the bits of addresses 0 to 2 that are not named below, are read/write storage kept separately for bank A (`cmd_bank_b`=0) and bank B (`cmd_bank_b`=1). A write to one bank leaves the other bank unchanged.
- R6: Bit 7 of address 0 is the reset-control bit:
  - in bank A it is read/write and drives `ctl_reset`;
  - in bank B it reads 0 and writes to it are ignored.
- R7: Bit 6 of address 1 is the output-enable bit:
  - it is writable only in bank A and drives `out_en`;
  - in bank B it reads the bank-A value, and bank-B writes to it are ignored.
- R8: Bit 7 of address 2 reads the live `pll_lock` input in both banks. Writes to it are ignored.
- R9: Bit 6 of address 2 reads the low-voltage latch in both banks, and writes to it are ignored. The latch behaves as follows:
  - `lv_detect` high at a clock edge sets it;
  - any byte moved at address 2, read or write, in either bank, clears it;
  - if `lv_detect` is high in the same cycle as a clearing byte, the latch stays set.
- R10: Address LAST_ADDR reads {4'b0000, `rssi_code`} in both banks, and writes to it are ignored.
- R11: Addresses above LAST_ADDR read 0x00 and ignore writes. A burst through them still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | 5 | Base address of the burst |
| cmd_len | input | 2 | Burst length minus one |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_bank_b | input | 1 | 1 = bank B, 0 = bank A |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte presented |
| rd_ready | input | 1 | Read byte consumed |
| rd_data | output | 8 | Read byte |
| pll_lock | input | 1 | Live lock status |
| lv_detect | input | 1 | Low-voltage detector output |
| rssi_code | input | 4 | Signal-strength converter result |
| ctl_reset | output | 1 | Bank-A reset-control bit |
| out_en | output | 1 | Bank-A output-enable bit |

## Verification
The bench builds the block with LAST_ADDR=5. This puts the converter byte, the wrap to 0x00 and the unimplemented addresses 6 to 31 within a four-byte burst.

The bank-A defaults are 0xA5 and the bank-B defaults are 0x3C, so every default differs from zero and between the banks. These values make it visible which bits reset masks off, which mirrored bits come from bank A, and whether a write leaked into the other bank.

// File: rtl/cfgbank_pkg.sv
`timescale 1ns/1ps
package cfgbank_pkg;
  localparam int ADDR_W   = 5;
  localparam int MAP_SIZE = 32;

  // fixed map positions that the access rules depend on
  localparam int CTRL_ADDR     = 0;
  localparam int OUTEN_ADDR    = 1;
  localparam int STAT_ADDR     = 2;
  localparam int CTRL_RST_BIT  = 7;
  localparam int OUTEN_BIT     = 6;
  localparam int STAT_LOCK_BIT = 7;
  localparam int STAT_LOWV_BIT = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [7:0]        byte_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WRITE = 2'd1,
    SEQ_READ  = 2'd2
  } seq_state_e;

  typedef struct packed {
    addr_t      base;
    logic [1:0] extra;
    logic       write;
    logic       bank_b;
  } cmd_t;

  // bits held in storage and writable for one register of one bank
  function automatic byte_t store_mask(input int addr, input bit bank_b, input int last_addr);
    byte_t m;
    if (addr >= last_addr)        m = 8'h00;                    // converter byte / unmapped
    else if (addr == CTRL_ADDR)   m = bank_b ? 8'h7F : 8'hFF;   // reset-control only in A
    else if (addr == OUTEN_ADDR)  m = bank_b ? 8'hBF : 8'hFF;   // output-enable owned by A
    else if (addr == STAT_ADDR)   m = 8'h3F;                    // lock and low-voltage are status
    else                          m = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/cfgbank_seq.sv
`timescale 1ns/1ps
module cfgbank_seq
  import cfgbank_pkg::*;
#(
  parameter int LAST_ADDR = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_valid,
  output logic  cmd_ready,
  input  cmd_t  cmd,
  input  logic  wr_valid,
  output logic  wr_ready,
  output logic  rd_valid,
  input  logic  rd_ready,
  output addr_t cur_addr,
  output logic  cur_bank_b,
  output logic  beat,
  output logic  beat_write
);
  localparam addr_t LAST = addr_t'(LAST_ADDR);

  seq_state_e state_q, state_d;
  addr_t      addr_q, addr_d, addr_next;
  logic [1:0] left_q, left_d;
  logic       bank_q, bank_d;

  assign cmd_ready  = (state_q == SEQ_IDLE);
  assign wr_ready   = (state_q == SEQ_WRITE);
  assign rd_valid   = (state_q == SEQ_READ);
  assign beat       = (wr_valid && wr_ready) || (rd_valid && rd_ready);
  assign beat_write = wr_ready;
  assign cur_addr   = addr_q;
  assign cur_bank_b = bank_q;

  // step with wrap once past the last implemented byte
  assign addr_next = (addr_q >= LAST) ? '0 : addr_q + addr_t'(1);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    bank_d  = bank_q;
    if (state_q == SEQ_IDLE) begin
      if (cmd_valid) begin
        state_d = cmd.write ? SEQ_WRITE : SEQ_READ;
        addr_d  = cmd.base;
        left_d  = cmd.extra;
        bank_d  = cmd.bank_b;
      end
    end else if (beat) begin
      addr_d = addr_next;
      if (left_q == 2'd0) state_d = SEQ_IDLE;
      else                left_d  = left_q - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      bank_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      bank_q  <= bank_d;
    end
  end

  // independent beat tally for the burst-length check
  logic [2:0] chk_seen;
  logic [1:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_seen <= '0;
      chk_len  <= '0;
    end else if (cmd_valid && cmd_ready) begin
      chk_seen <= '0;
      chk_len  <= cmd.extra;
    end else if (beat) begin
      chk_seen <= chk_seen + 3'd1;
    end
  end

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && $fell(cmd_ready)) |-> (chk_seen == 3'd0)); // R2
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && chk_seen == {1'b0, chk_len}) |=> cmd_ready); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && addr_q >= LAST && left_q != 2'd0) |=> (addr_q == '0)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && addr_q < LAST && left_q != 2'd0) |=> (addr_q == $past(addr_q) + addr_t'(1))); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !beat) |=> ($stable(addr_q) && $stable(state_q))); // R4
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid)); // R4
endmodule

// File: rtl/cfgbank_store.sv
`timescale 1ns/1ps
module cfgbank_store
  import cfgbank_pkg::*;
#(
  parameter int                    LAST_ADDR = 7,
  parameter logic [8*MAP_SIZE-1:0] DEF_A     = '0,
  parameter logic [8*MAP_SIZE-1:0] DEF_B     = '0,
  localparam int                   NREG      = LAST_ADDR + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  addr_t            wr_addr,
  input  logic             wr_bank_b,
  input  byte_t            wr_data,
  output logic [8*NREG-1:0] img_a,
  output logic [8*NREG-1:0] img_b
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar a = 0; a < NREG; a++) begin : g_reg
      localparam byte_t MASK = store_mask(a, (b == 1), LAST_ADDR);
      localparam byte_t INIT = ((b == 0) ? DEF_A[8*a +: 8] : DEF_B[8*a +: 8]) & MASK;

      byte_t q;
      logic  hit;
      assign hit = wr_en && (wr_addr == addr_t'(a)) && (wr_bank_b == (b == 1));

      always_ff @(posedge clk) begin
        if (!rst_n)   q <= INIT;
        else if (hit) q <= (q & ~MASK) | (wr_data & MASK);
      end

      AST_PROTECTED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~MASK) == (INIT & ~MASK))); // R5

      if (b == 0) begin : g_to_a
        assign img_a[8*a +: 8] = q;
      end else begin : g_to_b
        assign img_b[8*a +: 8] = q;
      end
    end
  end
endmodule

// File: rtl/cfgbank_lowv.sv
`timescale 1ns/1ps
module cfgbank_lowv (
  input  logic clk,
  input  logic rst_n,
  input  logic detect,
  input  logic clr,
  output logic flag
);
  // set has priority over a clearing access in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= detect | (flag & ~clr);
  end

  AST_LV_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> flag); // R9
  AST_LV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !detect) |=> !flag); // R9
  AST_LV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R9
endmodule

// File: rtl/cfgbank_view.sv
`timescale 1ns/1ps
module cfgbank_view
  import cfgbank_pkg::*;
#(
  parameter  int LAST_ADDR = 7,
  localparam int NREG      = LAST_ADDR + 1
) (
  input  addr_t             addr,
  input  logic              bank_b,
  input  logic [8*NREG-1:0] img_a,
  input  logic [8*NREG-1:0] img_b,
  input  logic              lock,
  input  logic              lowv,
  input  logic [3:0]        rssi,
  output byte_t             rd_byte
);
  localparam addr_t LAST = addr_t'(LAST_ADDR);

  byte_t stored_a, stored_b;

  always_comb begin
    stored_a = '0;
    stored_b = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == addr_t'(i)) begin
        stored_a = img_a[8*i +: 8];
        stored_b = img_b[8*i +: 8];
      end
    end

    if (addr > LAST) begin
      rd_byte = '0;
    end else if (addr == LAST) begin
      rd_byte = {4'b0000, rssi};
    end else begin
      rd_byte = bank_b ? stored_b : stored_a;
      if (addr == addr_t'(OUTEN_ADDR)) rd_byte[OUTEN_BIT] = stored_a[OUTEN_BIT];
      if (addr == addr_t'(STAT_ADDR)) begin
        rd_byte[STAT_LOCK_BIT] = lock;
        rd_byte[STAT_LOWV_BIT] = lowv;
      end
    end
  end
endmodule

// File: rtl/cfgbank_regfile.sv
`timescale 1ns/1ps
module cfgbank_regfile
  import cfgbank_pkg::*;
#(
  parameter int                    LAST_ADDR = 7,
  parameter logic [8*MAP_SIZE-1:0] DEF_A     = '0,
  parameter logic [8*MAP_SIZE-1:0] DEF_B     = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [4:0] cmd_addr,
  input  logic [1:0] cmd_len,
  input  logic       cmd_write,
  input  logic       cmd_bank_b,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  input  logic       pll_lock,
  input  logic       lv_detect,
  input  logic [3:0] rssi_code,
  output logic       ctl_reset,
  output logic       out_en
);
  localparam int    NREG = LAST_ADDR + 1;
  localparam addr_t LAST = addr_t'(LAST_ADDR);

  if (LAST_ADDR < 3 || LAST_ADDR > 31) begin : g_bad_last
    $error("LAST_ADDR must lie in 3..31");
  end

  cmd_t             cmd_s;
  addr_t            cur_addr;
  logic             cur_bank_b, beat, beat_write, lowv_flag;
  logic [8*NREG-1:0] img_a, img_b;

  assign cmd_s = '{base: cmd_addr, extra: cmd_len, write: cmd_write, bank_b: cmd_bank_b};

  cfgbank_seq #(.LAST_ADDR(LAST_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd(cmd_s),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .cur_addr(cur_addr), .cur_bank_b(cur_bank_b),
    .beat(beat), .beat_write(beat_write)
  );

  cfgbank_store #(.LAST_ADDR(LAST_ADDR), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(beat && beat_write), .wr_addr(cur_addr), .wr_bank_b(cur_bank_b),
    .wr_data(wr_data), .img_a(img_a), .img_b(img_b)
  );

  cfgbank_lowv u_lowv (
    .clk(clk), .rst_n(rst_n),
    .detect(lv_detect),
    .clr(beat && (cur_addr == addr_t'(STAT_ADDR))),
    .flag(lowv_flag)
  );

  cfgbank_view #(.LAST_ADDR(LAST_ADDR)) u_view (
    .addr(cur_addr), .bank_b(cur_bank_b),
    .img_a(img_a), .img_b(img_b),
    .lock(pll_lock), .lowv(lowv_flag), .rssi(rssi_code),
    .rd_byte(rd_data)
  );

  assign ctl_reset = img_a[8*CTRL_ADDR  + CTRL_RST_BIT];
  assign out_en    = img_a[8*OUTEN_ADDR + OUTEN_BIT];

  AST_BANK_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && beat_write && !cur_bank_b) |=> $stable(img_b)); // R5
  AST_CTRL_B_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && beat_write && cur_bank_b) |=> $stable(ctl_reset)); // R6
  AST_CTRL_B_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cur_bank_b && cur_addr == addr_t'(CTRL_ADDR)) |-> !rd_data[CTRL_RST_BIT]); // R6
  AST_OUTEN_B_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && beat_write && cur_bank_b) |=> $stable(out_en)); // R7
  AST_OUTEN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cur_addr == addr_t'(OUTEN_ADDR)) |-> (rd_data[OUTEN_BIT] == out_en)); // R7
  AST_LOCK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cur_addr == addr_t'(STAT_ADDR)) |-> (rd_data[STAT_LOCK_BIT] == pll_lock)); // R8
  AST_RSSI_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cur_addr == LAST) |-> (rd_data == {4'b0000, rssi_code})); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cur_addr > LAST) |-> (rd_data == 8'h00)); // R11
endmodule

// File: tb/cfgbank_regfile_bench.sv
`timescale 1ns/1ps
module cfgbank_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_bank_b = 1'b0;
  logic [4:0] cmd_addr = '0;
  logic [1:0] cmd_len = '0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pll_lock = 1'b1, lv_detect = 1'b0;
  logic [3:0] rssi_code = 4'h9;
  logic       cmd_ready, wr_ready, rd_valid, ctl_reset, out_en;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cfgbank_regfile #(
    .LAST_ADDR(5),
    .DEF_A({32{8'hA5}}),
    .DEF_B({32{8'h3C}})
  ) u_cfgbank_regfile (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_write(cmd_write), .cmd_bank_b(cmd_bank_b),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .pll_lock(pll_lock), .lv_detect(lv_detect), .rssi_code(rssi_code),
    .ctl_reset(ctl_reset), .out_en(out_en)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 50000);
      finish_run();
    end
  end

  // one full burst; read bytes checked against expect bytes, first byte in [31:24]
  task automatic burst(input logic wr, input logic bank, input logic [4:0] addr,
                       input logic [1:0] len, input logic [31:0] bytes, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_bank_b = bank; cmd_addr = addr; cmd_len = len;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int k = 0; k <= int'(len); k++) begin
      @(negedge clk);
      chk({7'b0, cmd_ready}, 8'h00, {tag, " busy R2"});
      if (wr) begin
        wr_valid = 1'b1;
        wr_data  = bytes[31-8*k -: 8];
        @(posedge clk); #1;
        wr_valid = 1'b0;
      end else begin
        rd_ready = 1'b1;
        #1;
        chk({7'b0, rd_valid}, 8'h01, {tag, " rd_valid R4"});
        chk(rd_data, bytes[31-8*k -: 8], tag);
        @(posedge clk); #1;
        rd_ready = 1'b0;
      end
    end
    @(negedge clk);
    chk({7'b0, cmd_ready}, 8'h01, {tag, " idle after burst R2"});
  endtask

  // {write, bank_b, addr, len, bytes}; lock=1, rssi=9, detector quiet
  localparam logic [40:0] VEC [16] = '{
    {1'b0, 1'b0, 5'd0,  2'd3, 32'hA5A5A5A5},  // R1 R5 R8 bank A defaults
    {1'b0, 1'b1, 5'd0,  2'd3, 32'h3C3CBC3C},  // R1 R6 bank B defaults masked
    {1'b1, 1'b0, 5'd3,  2'd1, 32'h11220000},  // R5
    {1'b1, 1'b1, 5'd2,  2'd3, 32'hFF010203},  // R8 R10 writes ignored on status
    {1'b0, 1'b1, 5'd2,  2'd3, 32'hBF010209},  // R5 R8 R10
    {1'b0, 1'b0, 5'd3,  2'd1, 32'h11220000},  // R5 bank A untouched by B
    {1'b1, 1'b0, 5'd1,  2'd0, 32'hC3000000},  // R7
    {1'b0, 1'b1, 5'd1,  2'd0, 32'h7C000000},  // R7 mirror of A
    {1'b1, 1'b1, 5'd0,  2'd1, 32'hFF000000},  // R6 R7 bank B writes
    {1'b0, 1'b1, 5'd0,  2'd1, 32'h7F400000},  // R6 R7
    {1'b0, 1'b0, 5'd0,  2'd1, 32'hA5C30000},  // R6 R7 bank A unchanged
    {1'b1, 1'b0, 5'd4,  2'd3, 32'h44556677},  // R3 R10 wrap after last
    {1'b0, 1'b0, 5'd4,  2'd3, 32'h44096677},  // R3 R10
    {1'b0, 1'b0, 5'd30, 2'd2, 32'h00667700},  // R3 R11 above last goes to 0
    {1'b1, 1'b1, 5'd31, 2'd1, 32'hAA5A0000},  // R11
    {1'b0, 1'b1, 5'd31, 2'd1, 32'h005A0000}   // R11 R6
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({7'b0, cmd_ready}, 8'h01, "R1 cmd_ready");
    chk({7'b0, wr_ready},  8'h00, "R1 wr_ready");
    chk({7'b0, rd_valid},  8'h00, "R1 rd_valid");
    chk({7'b0, ctl_reset}, 8'h01, "R1 ctl_reset");
    chk({7'b0, out_en},    8'h00, "R1 out_en");

    for (int v = 0; v < 16; v++) begin
      burst(VEC[v][40], VEC[v][39], VEC[v][38:34], VEC[v][33:32], VEC[v][31:0],
            $sformatf("table v%0d", v));
    end
    chk({7'b0, ctl_reset}, 8'h00, "R6 ctl_reset after A write");
    chk({7'b0, out_en},    8'h01, "R7 out_en after A write");

    // R4 stall: read held back for three cycles
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bank_b = 1'b0; cmd_addr = 5'd3; cmd_len = 2'd1;
    @(posedge clk); #1 cmd_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk({7'b0, rd_valid}, 8'h01, "R4 stall rd_valid");
      chk({7'b0, wr_ready}, 8'h00, "R4 stall wr_ready");
      chk(rd_data, 8'h11, "R4 stall data");
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      rd_ready = 1'b1;
      #1 chk(rd_data, (k == 0) ? 8'h11 : 8'h44, "R4 after stall");
      @(posedge clk); #1 rd_ready = 1'b0;
    end
    @(negedge clk);
    chk({7'b0, cmd_ready}, 8'h01, "R2 idle after stalled burst");

    burst(1'b0, 1'b1, 5'd4, 2'd0, 32'h02000000, "R2 single byte");

    // R8 live lock
    pll_lock = 1'b0;
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'h25000000, "R8 lock low A");
    burst(1'b0, 1'b1, 5'd2, 2'd0, 32'h3F000000, "R8 lock low B");
    pll_lock = 1'b1;

    // R9 latch, cleared by a bank-B read
    @(negedge clk); lv_detect = 1'b1;
    @(negedge clk); lv_detect = 1'b0;
    burst(1'b0, 1'b1, 5'd2, 2'd0, 32'hFF000000, "R9 latched");
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'hA5000000, "R9 cleared by read");

    // R9 detector wins over a clearing access
    lv_detect = 1'b1;
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'hE5000000, "R9 set while detect");
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'hE5000000, "R9 set wins");
    lv_detect = 1'b0;
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'hE5000000, "R9 kept");
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'hA5000000, "R9 now clear");

    // R9 cleared by a write from bank B
    @(negedge clk); lv_detect = 1'b1;
    @(negedge clk); lv_detect = 1'b0;
    burst(1'b1, 1'b1, 5'd2, 2'd0, 32'h00000000, "R9 write clear");
    burst(1'b0, 1'b0, 5'd2, 2'd0, 32'hA5000000, "R9 after write A");
    burst(1'b0, 1'b1, 5'd2, 2'd0, 32'h80000000, "R9 after write B");

    // R10 live converter code in both banks
    rssi_code = 4'hF;
    burst(1'b0, 1'b1, 5'd5, 2'd0, 32'h0F000000, "R10 rssi B");
    burst(1'b0, 1'b0, 5'd5, 2'd0, 32'h0F000000, "R10 rssi A");

    // R1 reset in the middle of a write burst
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_bank_b = 1'b0; cmd_addr = 5'd3; cmd_len = 2'd3;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h99;
    @(posedge clk); #1 wr_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({7'b0, cmd_ready}, 8'h01, "R1 idle after reset");
    chk({7'b0, wr_ready},  8'h00, "R1 wr_ready after reset");
    chk({7'b0, ctl_reset}, 8'h01, "R1 ctl_reset default");
    chk({7'b0, out_en},    8'h00, "R1 out_en default");
    burst(1'b0, 1'b0, 5'd0, 2'd3, 32'hA5A5A5A5, "R1 defaults again");

    finish_run();
  end
endmodule